// File: doc/BRIEF.md
# Offset-Adder Address Register Bank

This block holds a small set of address registers for a simple processor. The register chosen by the select input drives the memory address bus. A register is never loaded directly. Every write goes through an address adder, and the result is committed on the rising clock edge when the write-enable is high.

The adder takes one of two bases. Normally the base is the selected register itself. When the bridge input is high, the base is the data bus instead. A two-bit option code picks the offset:

- +1 or -1.
- An 8-bit instruction displacement, zero-extended.
- The same displacement with the upper byte forced to ones, which is the same as adding it plus 0xFF00.

In bridge mode the two lower codes become +0 and +1, so a value from the data bus can be copied in unchanged or incremented by one. All sums wrap modulo 2^16, and no carry is reported.

Top module: `addr_reg_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to 0x0000.
- R2: `addr_out` follows the stored value of the register chosen by `sel` combinationally. It never shows the adder result before the clock edge.
- R3: With `bridge_en`=0 and `opt`=2'b00, a write stores the selected register plus 1.
- R4: With `bridge_en`=0 and `opt`=2'b01, a write stores the selected register minus 1. 0x0000 becomes 0xFFFF.
- R5: With `bridge_en`=0 and `opt`=2'b10, a write stores the selected register plus {8'h00, `ival`}.
- R6: With `bridge_en`=0 and `opt`=2'b11, a write stores the selected register plus {8'hFF, `ival`}.
- R7: With `bridge_en`=1, `opt`=2'b00 stores `data_bus` unchanged and `opt`=2'b01 stores `data_bus`+1.
- R8: With `bridge_en`=1, `opt`=2'b10 and 2'b11 add the same displacement offsets as R5 and R6, but to `data_bus`.
- R9: When `wr_en` is 0, no register changes, whatever the other inputs are.
- R10: A write changes only the register chosen by `sel`. The other registers keep their values.
- R11: Every sum wraps modulo 2^16. For example, 0xFFFF+1 gives 0x0000 and 0x0100+0xFF00 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Register that is read onto the bus and that is the write target |
| opt | input | 2 | Offset option code |
| bridge_en | input | 1 | When high, the adder base is the data bus instead of the register |
| ival | input | 8 | Displacement byte taken from the current instruction |
| data_bus | input | 16 | Base value used in bridge mode |
| wr_en | input | 1 | When high, the adder result is committed at the clock edge |
| addr_out | output | 16 | Stored value of the selected register |

## Verification
A write is due exactly one rising edge after its inputs are set up. A change of `sel` shows on `addr_out` in the same cycle, with no edge needed.

The bench changes inputs on the falling edge and samples `addr_out` 1 ns after the following rising edge. A write result is therefore read in the first cycle in which it can be visible.

For R2, the bench moves `sel` while the clock is idle and samples `addr_out` after 1 ns of settling. In that case no edge stands between the stimulus and the check.

// File: rtl/addr_reg_pkg.sv
package addr_reg_pkg;

  typedef enum logic [1:0] {
    ADJ_STEP_UP   = 2'b00,
    ADJ_STEP_DOWN = 2'b01,
    ADJ_DISP_LO   = 2'b10,
    ADJ_DISP_HI   = 2'b11
  } adj_op_e;

endpackage

// File: rtl/addr_offset_gen.sv
module addr_offset_gen
  import addr_reg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [1:0]        opt,
  input  logic              bridge_en,
  input  logic [DISP_W-1:0] ival,
  output logic [ADDR_W-1:0] offset
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] one_c;
  logic [ADDR_W-1:0] zero_ext;
  logic [ADDR_W-1:0] ones_ext;

  assign one_c    = ADDR_W'(1);
  assign zero_ext = {{EXT_W{1'b0}}, ival};
  assign ones_ext = {{EXT_W{1'b1}}, ival};

  always_comb begin
    unique case (adj_op_e'(opt))
      ADJ_STEP_UP:   offset = bridge_en ? '0    : one_c;
      ADJ_STEP_DOWN: offset = bridge_en ? one_c : '1;
      ADJ_DISP_LO:   offset = zero_ext;
      ADJ_DISP_HI:   offset = ones_ext;
      default:       offset = one_c;
    endcase
  end
endmodule

// File: rtl/addr_base_adder.sv
module addr_base_adder #(
  parameter int ADDR_W = 16
) (
  input  logic              bridge_en,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] data_bus,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] sum
);
  logic [ADDR_W-1:0] base;

  assign base = bridge_en ? data_bus : reg_val;
  assign sum  = base + offset;
endmodule

// File: rtl/addr_reg_store.sv
module addr_reg_store #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata
);
  logic [ADDR_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && (sel == SEL_W'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata = regs[sel];
endmodule

// File: rtl/addr_reg_bank.sv
module addr_reg_bank #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int DISP_W   = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        opt,
  input  logic              bridge_en,
  input  logic [DISP_W-1:0] ival,
  input  logic [ADDR_W-1:0] data_bus,
  input  logic              wr_en,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] cur;

  addr_offset_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_offset (
    .opt       (opt),
    .bridge_en (bridge_en),
    .ival      (ival),
    .offset    (offset)
  );

  addr_base_adder #(.ADDR_W(ADDR_W)) u_adder (
    .bridge_en (bridge_en),
    .reg_val   (cur),
    .data_bus  (data_bus),
    .offset    (offset),
    .sum       (sum)
  );

  addr_reg_store #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .sel   (sel),
    .wdata (sum),
    .rdata (cur)
  );

  assign addr_out = cur;
endmodule

// File: rtl/addr_reg_bank_chk.sv
module addr_reg_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  sel,
  input logic [1:0]        opt,
  input logic              bridge_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] data_bus,
  input logic [ADDR_W-1:0] addr_out
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> addr_out == '0); // R1

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en ##1 (sel == $past(sel)) |-> $stable(addr_out)); // R9

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bridge_en && opt == 2'b00) ##1 (sel == $past(sel))
    |-> addr_out == ADDR_W'($past(addr_out) + ADDR_W'(1))); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bridge_en && opt == 2'b01) ##1 (sel == $past(sel))
    |-> addr_out == ADDR_W'($past(addr_out) - ADDR_W'(1))); // R4

  AST_BRIDGE_COPY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bridge_en && opt == 2'b00) ##1 (sel == $past(sel))
    |-> addr_out == $past(data_bus)); // R7

endmodule

bind addr_reg_bank addr_reg_bank_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .opt       (opt),
  .bridge_en (bridge_en),
  .wr_en     (wr_en),
  .data_bus  (data_bus),
  .addr_out  (addr_out)
);

// File: tb/test_addr_reg_bank.sv
module test_addr_reg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  sel = '0;
  logic [1:0]  opt = '0;
  logic        bridge_en = 1'b0;
  logic [7:0]  ival = '0;
  logic [15:0] data_bus = '0;
  logic        wr_en = 1'b0;
  logic [15:0] addr_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  addr_reg_bank i_addr_reg_bank (
    .clk(clk), .rst(rst), .sel(sel), .opt(opt), .bridge_en(bridge_en),
    .ival(ival), .data_bus(data_bus), .wr_en(wr_en), .addr_out(addr_out)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [1:0]  opt;
    logic        br;
    logic        we;
    logic [7:0]  iv;
    logic [15:0] db;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'b00, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0001, 4'd3},  // R3
    '{2'd0, 2'b01, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0000, 4'd4},  // R4
    '{2'd0, 2'b01, 1'b0, 1'b1, 8'h00, 16'h0000, 16'hFFFF, 4'd4},  // R4 wrap down
    '{2'd0, 2'b00, 1'b0, 1'b1, 8'h00, 16'h0000, 16'h0000, 4'd11}, // R11
    '{2'd1, 2'b00, 1'b1, 1'b1, 8'h00, 16'h1234, 16'h1234, 4'd7},  // R7 copy
    '{2'd1, 2'b01, 1'b1, 1'b1, 8'h00, 16'hABCD, 16'hABCE, 4'd7},  // R7 +1
    '{2'd1, 2'b10, 1'b0, 1'b1, 8'h80, 16'h0000, 16'hAC4E, 4'd5},  // R5
    '{2'd1, 2'b11, 1'b0, 1'b1, 8'h10, 16'h0000, 16'hAB5E, 4'd6},  // R6
    '{2'd2, 2'b10, 1'b1, 1'b1, 8'hFF, 16'h1000, 16'h10FF, 4'd8},  // R8
    '{2'd3, 2'b11, 1'b1, 1'b1, 8'h20, 16'h0050, 16'hFF70, 4'd8},  // R8
    '{2'd3, 2'b00, 1'b1, 1'b0, 8'h55, 16'h7777, 16'hFF70, 4'd9},  // R9
    '{2'd0, 2'b11, 1'b1, 1'b1, 8'h00, 16'h0100, 16'h0000, 4'd11}  // R11
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1 check("R1 reset state", addr_out, 16'h0000);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel = VECS[i].sel; opt = VECS[i].opt; bridge_en = VECS[i].br;
      wr_en = VECS[i].we; ival = VECS[i].iv; data_bus = VECS[i].db;
      @(posedge clk);
      #1 check($sformatf("R%0d vector %0d", VECS[i].req, i), addr_out, VECS[i].exp);
    end

    @(negedge clk);
    wr_en = 1'b0;
    sel = 2'd0; #1 check("R10 reg0 kept", addr_out, 16'h0000);
    sel = 2'd1; #1 check("R10 reg1 kept", addr_out, 16'hAB5E);
    sel = 2'd2; #1 check("R10 reg2 kept", addr_out, 16'h10FF);
    sel = 2'd3; #1 check("R10 reg3 kept", addr_out, 16'hFF70);

    // R2: a pending write must not show before the edge
    @(negedge clk);
    sel = 2'd2; opt = 2'b10; bridge_en = 1'b1; data_bus = 16'h4000; ival = 8'h01; wr_en = 1'b1;
    #1 check("R2 no adder bypass", addr_out, 16'h10FF);
    @(posedge clk);
    #1 check("R8 bridge write after edge", addr_out, 16'h4001);
    @(negedge clk);
    wr_en = 1'b0;
    sel = 2'd1; #1 check("R2 select follows", addr_out, 16'hAB5E);

    // R9: no-write cycles with live operands leave the register alone
    opt = 2'b00; bridge_en = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R9 hold without write", addr_out, 16'hAB5E);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1 check("R1 reset clears", addr_out, 16'h0000);
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end

endmodule